// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores incoming frames into a circular receive area in local memory and keeps the ring pointers that a host needs to consume them. The memory is seen as 256-byte pages. Two configuration inputs bound the ring: a first page and a limit page. The ring covers every page from the first page up to the page just below the limit page. A current-page register shows where the next frame will land. The host reports how far it has read through a boundary-page input.

Frame bytes arrive one per cycle on a valid/last stream that also carries per-frame error and group-address flags, plus an overrun flag that can appear on any byte. The payload goes into the current page starting at offset 4 and runs forward across pages, wrapping at the limit page. After the last byte, four header bytes go into offsets 0..3 of the frame's first page. Only then does the current page move to the page after the one holding the final byte. A frame that would run into the boundary page, a frame received in monitor mode, and a frame cut short by an overrun all leave the current page where it was. Each frame ends with a one-cycle event that carries its status byte.

Top module: `rxr_ring_mgr`

## Requirements
- R1: Every memory write targets a page p with first_page <= p < limit_page. When a payload crosses the end of the page just below limit_page, it continues at first_page.
- R2: For a stored frame, byte i of the payload is written at page-relative position 4+i of the current page, continuing at offset 0 of each following ring page. There is one write per accepted byte, in order.
- R3: After the payload, four header writes go to offsets 0, 1, 2 and 3 of the frame's first page, on four consecutive cycles. Their contents are the status byte, the next-packet page, the low byte of (length+4), and the high byte of (length+4).
- R4: Status byte bits: 0 stored without error, 1 CRC error, 2 alignment error, 3 overrun, 4 missed, 5 group-address match, 6 monitor mode, 7 always 0. Bit 0 is set only for a stored frame that has neither bit 1 nor bit 2 set.
- R5: The next-packet page is the ring page following the page that holds the last payload byte. The current-page output takes this value in the same cycle that the frame event is raised, which is four cycles after the last byte is accepted.
- R6: The block never writes the boundary page. Two cases make a frame missed: the current page already equals the boundary at the first byte, or advancing to a new page (mid-frame or as the next-packet page) would reach the boundary. A missed frame raises the overwrite output together with its event, sets status bit 4, writes no header and leaves the current page unchanged.
- R7: While monitor mode is set at a frame's first byte, nothing is written and the event reports status bits 4 and 6.
- R8: An overrun flag on an accepted byte stops all writes for the rest of that frame. It writes no header, leaves the current page unchanged and reports bit 3 without bit 4.
- R9: The missed-frame count rises by one with each event that has bit 4 set, and it saturates at its maximum value.
- R10: While the ring enable is low, the current page loads first_page every cycle, in_ready is low and stream input is ignored. After the last byte of a stored frame, in_ready is low for exactly 4 cycles.
- R11: After reset, the current page, the missed-frame count, mem_we, evt_valid and in_ready are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_en | input | 1 | Ring enable; low reloads the current page |
| cfg_start_page | input | PAGE_W | First ring page |
| cfg_stop_page | input | PAGE_W | Limit page (first page past the ring) |
| host_bnd_page | input | PAGE_W | Boundary page still owned by the host |
| cfg_monitor | input | 1 | Monitor mode: check frames, store nothing |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_crc_err | input | 1 | CRC error flag, sampled with the last byte |
| in_align_err | input | 1 | Alignment error flag, sampled with the last byte |
| in_group | input | 1 | Group-address match flag, sampled with the last byte |
| in_overrun | input | 1 | Overrun on this byte; aborts storage |
| in_ready | output | 1 | Block can take a byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PAGE_W+8 | Write address {page, offset} |
| mem_wdata | output | 8 | Write data |
| cur_page | output | PAGE_W | Current receive page |
| evt_valid | output | 1 | One-cycle frame-end event |
| evt_status | output | 8 | Status byte of the finished frame |
| evt_overwrite | output | 1 | Frame dropped for lack of ring space |
| miss_count | output | CNT_W | Saturating missed-frame count |

## Verification
Nearly every internal slip reaches the write port within one cycle. A wrong page or offset register sends the next write to the wrong address, and a wrong page-advance decision shows up as a write to the boundary page or outside the ring. A stale frame-state register shows up later: as a missing or extra header write, as a current page that moves on a dropped frame, or as a status byte whose bits disagree with the frame flags. The reference model checks the address and data of every write as it happens, and it checks the current page and miss count at every event.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int OFF_W     = 8;
    localparam int HDR_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_HDR  = 2'd3
    } rxr_state_e;

    localparam int SB_OK  = 0;
    localparam int SB_CRC = 1;
    localparam int SB_ALN = 2;
    localparam int SB_FO  = 3;
    localparam int SB_MPA = 4;
    localparam int SB_GRP = 5;
    localparam int SB_DIS = 6;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [PAGE_W-1:0] stop_page,
    output logic [PAGE_W-1:0] next_page
);
    logic [PAGE_W-1:0] inc;

    assign inc       = page + {{(PAGE_W-1){1'b0}}, 1'b1};
    assign next_page = (inc == stop_page) ? start_page : inc;
endmodule

// File: rtl/rxr_sat_counter.sv
module rxr_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/rxr_ring_mgr.sv
module rxr_ring_mgr
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ring_en,
    input  logic [PAGE_W-1:0]        cfg_start_page,
    input  logic [PAGE_W-1:0]        cfg_stop_page,
    input  logic [PAGE_W-1:0]        host_bnd_page,
    input  logic                     cfg_monitor,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    input  logic                     in_last,
    input  logic                     in_crc_err,
    input  logic                     in_align_err,
    input  logic                     in_group,
    input  logic                     in_overrun,
    output logic                     in_ready,
    output logic                     mem_we,
    output logic [PAGE_W+OFF_W-1:0]  mem_addr,
    output logic [7:0]               mem_wdata,
    output logic [PAGE_W-1:0]        cur_page,
    output logic                     evt_valid,
    output logic [7:0]               evt_status,
    output logic                     evt_overwrite,
    output logic [CNT_W-1:0]         miss_count
);
    localparam int AW = PAGE_W + OFF_W;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_HDR = LEN_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] OFF_PAY = OFF_W'(HDR_BYTES);
    localparam logic [OFF_W-1:0] OFF_END = '1;

    typedef struct packed {
        rxr_state_e        st;
        logic [PAGE_W-1:0] cur;
        logic [PAGE_W-1:0] wp;
        logic [PAGE_W-1:0] nxt;
        logic [OFF_W-1:0]  off;
        logic [LEN_W-1:0]  len;
        logic [7:0]        fl;
        logic              ovw;
        logic [1:0]        hidx;
        logic              we;
        logic [AW-1:0]     addr;
        logic [7:0]        wdata;
        logic              ev;
        logic [7:0]        evst;
        logic              evovw;
    } regs_t;

    regs_t q, d;

    logic              first, accept, miss_inc;
    logic [PAGE_W-1:0] wp_base, wp_step;
    logic [15:0]       hdr_cnt;

    assign first   = (q.st == ST_IDLE);
    assign accept  = in_valid && ring_en && (q.st != ST_HDR);
    assign wp_base = first ? q.cur : q.wp;
    assign hdr_cnt = 16'(q.len);

    rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
        .page       (wp_base),
        .start_page (cfg_start_page),
        .stop_page  (cfg_stop_page),
        .next_page  (wp_step)
    );

    rxr_sat_counter #(.W(CNT_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (miss_inc),
        .count (miss_count)
    );

    always_comb begin
        logic [7:0]        fl;
        logic [PAGE_W-1:0] wp;
        logic [OFF_W-1:0]  off;
        logic [LEN_W-1:0]  len;
        logic              drop, ovw;

        d        = q;
        d.we     = 1'b0;
        d.ev     = 1'b0;
        d.evovw  = 1'b0;
        miss_inc = 1'b0;
        fl       = first ? 8'h00 : q.fl;
        wp       = wp_base;
        off      = first ? OFF_PAY : q.off;
        len      = first ? '0 : q.len;
        drop     = first ? 1'b0 : (q.st == ST_DROP);
        ovw      = first ? 1'b0 : q.ovw;

        if (!ring_en) begin
            d.st  = ST_IDLE;
            d.cur = cfg_start_page;
        end else if (q.st == ST_HDR) begin
            d.we   = 1'b1;
            d.addr = {q.cur, 6'd0, q.hidx};
            case (q.hidx)
                2'd0:    d.wdata = q.fl;
                2'd1:    d.wdata = 8'(q.nxt);
                2'd2:    d.wdata = hdr_cnt[7:0];
                default: d.wdata = hdr_cnt[15:8];
            endcase
            d.hidx = q.hidx + 2'd1;
            if (q.hidx == 2'd3) begin
                d.cur  = q.nxt;
                d.st   = ST_IDLE;
                d.ev   = 1'b1;
                d.evst = q.fl;
            end
        end else if (accept) begin
            if (first) begin
                if (cfg_monitor) begin
                    fl[SB_DIS] = 1'b1;
                    fl[SB_MPA] = 1'b1;
                    drop       = 1'b1;
                end else if (q.cur == host_bnd_page) begin
                    fl[SB_MPA] = 1'b1;
                    ovw        = 1'b1;
                    drop       = 1'b1;
                end
            end
            len = len + LEN_ONE;
            if (!drop && in_overrun) begin
                fl[SB_FO] = 1'b1;
                drop      = 1'b1;
            end
            if (!drop) begin
                d.we    = 1'b1;
                d.addr  = {wp, off};
                d.wdata = in_data;
                if (in_last || off == OFF_END) begin
                    if (wp_step == host_bnd_page) begin
                        fl[SB_MPA] = 1'b1;
                        ovw        = 1'b1;
                        drop       = 1'b1;
                    end else if (!in_last) begin
                        wp = wp_step;
                    end
                end
                off = off + 1'b1;
            end
            if (in_last) begin
                fl[SB_CRC] = fl[SB_CRC] | in_crc_err;
                fl[SB_ALN] = fl[SB_ALN] | in_align_err;
                fl[SB_GRP] = fl[SB_GRP] | in_group;
                if (drop) begin
                    d.st     = ST_IDLE;
                    d.ev     = 1'b1;
                    d.evst   = fl;
                    d.evovw  = ovw;
                    miss_inc = fl[SB_MPA];
                end else begin
                    fl[SB_OK] = !(in_crc_err || in_align_err);
                    d.st      = ST_HDR;
                    d.hidx    = 2'd0;
                    d.nxt     = wp_step;
                    d.len     = len + LEN_HDR;
                    d.fl      = fl;
                end
            end else begin
                d.st  = drop ? ST_DROP : ST_RECV;
                d.fl  = fl;
                d.ovw = ovw;
                d.wp  = wp;
                d.off = off;
                d.len = len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready      = ring_en && (q.st != ST_HDR);
    assign mem_we        = q.we;
    assign mem_addr      = q.addr;
    assign mem_wdata     = q.wdata;
    assign cur_page      = q.cur;
    assign evt_valid     = q.ev;
    assign evt_status    = q.evst;
    assign evt_overwrite = q.evovw;
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PAGE_W-1:0]       cfg_start_page,
    input logic [PAGE_W-1:0]       cfg_stop_page,
    input logic [PAGE_W-1:0]       host_bnd_page,
    input logic                    mem_we,
    input logic [PAGE_W+8-1:0]     mem_addr,
    input logic [PAGE_W-1:0]       cur_page,
    input logic                    evt_valid,
    input logic [7:0]              evt_status,
    input logic                    evt_overwrite,
    input logic [CNT_W-1:0]        miss_count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [PAGE_W-1:0] wr_page;
    assign wr_page = mem_addr[PAGE_W+8-1:8];

    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_page >= cfg_start_page && wr_page < cfg_stop_page)); // R1
    AST_NO_BND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_page != host_bnd_page); // R6
    AST_MISS_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_status[4]) |-> cur_page == $past(cur_page)); // R6
    AST_OVW_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_overwrite |-> (evt_valid && evt_status[4])); // R6
    AST_MON_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_status[6]) |-> evt_status[4]); // R7
    AST_FO_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_status[3]) |-> (!evt_status[4] && !evt_status[0])); // R8
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_status[0]) |-> (!evt_status[1] && !evt_status[2] && !evt_status[7])); // R4
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_status[4] && $past(miss_count) != CNT_TOP)
            |-> miss_count == $past(miss_count) + 1'b1); // R9
endmodule

bind rxr_ring_mgr rxr_ring_chk #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start_page (cfg_start_page),
    .cfg_stop_page  (cfg_stop_page),
    .host_bnd_page  (host_bnd_page),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .cur_page       (cur_page),
    .evt_valid      (evt_valid),
    .evt_status     (evt_status),
    .evt_overwrite  (evt_overwrite),
    .miss_count     (miss_count)
);

// File: tb/sim_rxr_ring_mgr.sv
`timescale 1ns/1ps
module sim_rxr_ring_mgr;
    localparam int PW = 8;
    localparam int CW = 2;
    localparam int CMAX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_en = 1'b0;
    logic [PW-1:0] cfg_start = 8'h10, cfg_stop = 8'h14, bnd = 8'h13;
    logic mon = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_crc = 1'b0, in_aln = 1'b0;
    logic in_grp = 1'b0, in_ovr = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, mem_we, evt_valid, evt_overwrite;
    logic [PW+7:0] mem_addr;
    logic [7:0] mem_wdata, evt_status;
    logic [PW-1:0] cur_page;
    logic [CW-1:0] miss_count;

    int nchk = 0, nbad = 0;
    int mcur = 0, mmiss = 0;
    int q_addr[$], q_data[$];
    string q_tag[$];
    int e_st[$], e_ovw[$], e_cur[$], e_miss[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxr_ring_mgr #(.PAGE_W(PW), .LEN_W(16), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_en(ring_en),
        .cfg_start_page(cfg_start), .cfg_stop_page(cfg_stop),
        .host_bnd_page(bnd), .cfg_monitor(mon),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_crc_err(in_crc), .in_align_err(in_aln), .in_group(in_grp),
        .in_overrun(in_ovr), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .evt_valid(evt_valid), .evt_status(evt_status),
        .evt_overwrite(evt_overwrite), .miss_count(miss_count)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int nxtp(int p);
        return ((p + 1) % 256 == int'(cfg_stop)) ? int'(cfg_start) : (p + 1) % 256;
    endfunction

    // every-clock comparison of write port and events against the model queues
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_we) begin
                if (q_addr.size() == 0) chk("R2 unexpected write", int'(mem_addr), -1);
                else begin
                    string t;
                    int a, dd;
                    t = q_tag.pop_front(); a = q_addr.pop_front(); dd = q_data.pop_front();
                    chk(t, {int'(mem_addr), 8'h00} | int'(mem_wdata), (a << 8) | dd);
                end
            end
            if (evt_valid) begin
                if (e_st.size() == 0) chk("R4 unexpected event", int'(evt_status), -1);
                else begin
                    chk("R4 status", int'(evt_status), e_st.pop_front());
                    chk("R6 overwrite", int'(evt_overwrite), e_ovw.pop_front());
                    chk("R5 cur page", int'(cur_page), e_cur.pop_front());
                    chk("R9 miss count", int'(miss_count), e_miss.pop_front());
                end
            end
        end
    end

    task automatic push_wr(string t, int a, int dd);
        q_tag.push_back(t); q_addr.push_back(a); q_data.push_back(dd);
    endtask

    task automatic send_frame(int len, int seed, bit crc, bit aln, bit grp, int ovr_at);
        int p, o, st, np, n;
        bit drop, ovw, stored;
        st = 0; drop = 0; ovw = 0; stored = 0; np = 0;
        if (mon) begin st = 8'h50; drop = 1; end
        else if (mcur == int'(bnd)) begin st = 8'h10; ovw = 1; drop = 1; end
        p = mcur; o = 4;
        for (int i = 0; i < len; i++) begin
            if (!drop && i == ovr_at) begin st |= 8'h08; drop = 1; end
            if (!drop) begin
                push_wr((p == mcur) ? "R2 payload" : "R1 wrapped payload",
                        p * 256 + o, (i * 7 + seed) & 255);
                if (i == len - 1) begin
                    np = nxtp(p);
                    if (np == int'(bnd)) begin st |= 8'h10; ovw = 1; drop = 1; end
                    else stored = 1;
                end else if (o == 255) begin
                    if (nxtp(p) == int'(bnd)) begin st |= 8'h10; ovw = 1; drop = 1; end
                    else p = nxtp(p);
                end
                o = (o + 1) & 255;
            end
        end
        st |= (int'(crc) << 1) | (int'(aln) << 2) | (int'(grp) << 5);
        if (stored) begin
            if (!crc && !aln) st |= 1;
            push_wr("R3 hdr status", mcur * 256 + 0, st);
            push_wr("R3 hdr next", mcur * 256 + 1, np);
            push_wr("R3 hdr cnt lo", mcur * 256 + 2, (len + 4) & 255);
            push_wr("R3 hdr cnt hi", mcur * 256 + 3, (len + 4) >> 8);
            mcur = np;
        end else if (st & 8'h10) begin
            if (mmiss < CMAX) mmiss++;
        end
        e_st.push_back(st); e_ovw.push_back(int'(ovw));
        e_cur.push_back(mcur); e_miss.push_back(mmiss);

        @(negedge clk);
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = 8'((i * 7 + seed) & 255);
            in_last  = (i == len - 1);
            in_ovr   = (i == ovr_at);
            in_crc   = crc; in_aln = aln; in_grp = grp;
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_ovr = 1'b0;
        in_crc = 1'b0; in_aln = 1'b0; in_grp = 1'b0;
        if (stored) begin
            n = 0;
            while (!in_ready && n < 20) begin n++; @(negedge clk); end
            chk("R10 header busy cycles", n, 4);
        end else begin
            chk("R10 ready after drop", int'(in_ready), 1);
        end
        repeat (3) @(negedge clk);
        chk("R5 cur after frame", int'(cur_page), mcur);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 cur reset", int'(cur_page), 0);
        chk("R11 miss reset", int'(miss_count), 0);
        chk("R11 we reset", int'(mem_we), 0);
        chk("R11 evt reset", int'(evt_valid), 0);
        chk("R11 ready reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 cur loads start", int'(cur_page), 8'h10);
        chk("R10 not ready while disabled", int'(in_ready), 0);
        ring_en = 1'b1; mcur = 8'h10;
        @(negedge clk);

        send_frame(60, 3, 0, 0, 0, -1);      // clean store
        send_frame(100, 11, 1, 0, 0, -1);    // CRC error stored
        send_frame(10, 5, 0, 0, 1, -1);      // next page hits boundary
        bnd = 8'h11;
        send_frame(300, 9, 0, 0, 0, -1);     // R1 crosses page and wraps
        send_frame(260, 1, 0, 0, 1, -1);     // overflow mid-frame
        mon = 1'b1;
        send_frame(20, 2, 0, 0, 0, -1);      // R7 monitor
        mon = 1'b0;
        send_frame(30, 4, 0, 0, 0, 5);       // R8 overrun mid-frame
        send_frame(8, 6, 1, 0, 0, 7);        // R8 overrun on last byte
        bnd = 8'h13;
        send_frame(252, 8, 0, 1, 0, -1);     // last byte at offset 255

        // R10: disabled ring ignores input and reloads start page
        ring_en = 1'b0;
        @(negedge clk);
        cfg_start = 8'h20; cfg_stop = 8'h22; bnd = 8'h21;
        in_valid = 1'b1; in_last = 1'b1; in_data = 8'hAA;
        repeat (2) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R10 reload start page", int'(cur_page), 8'h20);
        chk("R10 no event while disabled", e_st.size(), 0);
        ring_en = 1'b1; mcur = 8'h20;
        @(negedge clk);

        send_frame(10, 12, 0, 0, 0, -1);     // R9 saturating miss count
        bnd = 8'h20;
        send_frame(5, 13, 0, 0, 0, -1);      // R6 cur equals boundary at start

        repeat (4) @(negedge clk);
        chk("R2 all writes seen", q_addr.size(), 0);
        chk("R4 all events seen", e_st.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule